// File: doc/BRIEF.md
# Display Transmitter Control Register Target

This block is an I2C target that models the control port of a display transmitter. A host on the two-wire bus addresses it at a fixed 7-bit address and talks to a small register space of 256 byte locations. In each transfer addressed for write, the first byte the host sends selects a location. Every later byte moves the location pointer forward by one, whether it is read or written.

Three locations carry behaviour. At 0x1A the host can ask for the monitor-data side channel and have that request granted. A write there with both the request bit and the grant bit set puts the block into side-channel mode, which it reports on an output pin. The block then confirms the request on readback. Location 0x1B reads as a fixed identification byte. Location 0x3D reports that a sink is attached and that no interrupt is pending. All other locations read as zero, and writes to them are discarded.

The bus lines are synchronised to the system clock. The target drives the data line only by pulling it low, through an output enable.

Top module: `disp_i2c_target`

## Requirements
- R1: The target acknowledges a header whose upper seven bits equal DEV_ADDR. Any other header gets no acknowledge, and the bytes that follow it until the next START change no state.
- R2: The first byte written after a START with a write header (bit 0 = 0) loads the pointer. That byte is not applied to any register.
- R3: After each data byte the target reads out or accepts as a register write, the pointer increases by one, modulo 256.
- R4: A write to 0x1A with bit 2 set records a pending request. If bit 1 is also set in that byte, ddc_mode_o goes to 1.
- R5: A write to 0x1A with bit 2 clear clears both the pending request and ddc_mode_o.
- R6: A read of 0x1A returns 0x06 while a request is pending and 0x00 otherwise.
- R7: A read of 0x1B returns 0xB0.
- R8: A read of 0x3D returns 0x04.
- R9: All other locations read as 0x00. Writes to them are acknowledged and have no effect.
- R10: After reset the pointer is 0, no request is pending, ddc_mode_o is 0 and the data line is released.
- R11: While reading, the target presents the next byte after each master ACK and releases the line after a master NACK. A repeated START with a read header keeps the current pointer.
- R12: A START or STOP that arrives in the middle of a byte ends the transfer. The partial byte has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| ddc_mode_o | output | 1 | Side-channel mode flag |

## Verification
The bench builds the block with DEV_ADDR = 0x39 and two synchroniser stages. Its master is slow enough that every bus phase spans several system clocks. With the 8-bit pointer, the bench can sweep long runs of consecutive reads across all three decoded locations and also across the wrap from 0xFF to 0x00. The bench also sends headers for 0x38, which differs from the target address only in the last address bit, and for 0x50. These confirm that a near miss is not acknowledged.

// File: rtl/disp_i2c_pkg.sv
package disp_i2c_pkg;
  localparam int unsigned DW = 8;

  localparam logic [DW-1:0] REG_SYSCTL  = 8'h1A;
  localparam logic [DW-1:0] REG_ID      = 8'h1B;
  localparam logic [DW-1:0] REG_IRQ     = 8'h3D;
  localparam logic [DW-1:0] ID_VALUE    = 8'hB0;
  localparam logic [DW-1:0] IRQ_PRESENT = 8'h04;
  localparam logic [DW-1:0] SYSCTL_ACK  = 8'h06;
  localparam int unsigned   REQ_BIT     = 2;
  localparam int unsigned   GNT_BIT     = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/disp_i2c_sync.sv
module disp_i2c_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d, scl_s, sda_s;

  assign scl_s = scl_sr[STAGES-1];
  assign sda_s = sda_sr[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // data edges while the clock line stays high
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/disp_i2c_fsm.sv
module disp_i2c_fsm
  import disp_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h39
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_s_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          sda_oe_o,
  output logic          wstart_o,
  output logic          wr_stb_o,
  output logic [DW-1:0] wr_data_o,
  output logic          rd_stb_o
);
  localparam int unsigned CW = $clog2(DW);

  tgt_state_e    state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rx_sh, tx_sh;
  logic          done, rw, mack, oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      done     <= 1'b0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      oe       <= 1'b0;
      wstart_o <= 1'b0;
      wr_stb_o <= 1'b0;
      rd_stb_o <= 1'b0;
    end else begin
      wstart_o <= 1'b0;
      wr_stb_o <= 1'b0;
      rd_stb_o <= 1'b0;
      if (start_i) begin
        state <= ST_ADDR;
        cnt   <= '0;
        done  <= 1'b0;
        oe    <= 1'b0;
      end else if (stop_i) begin
        state <= ST_IDLE;
        done  <= 1'b0;
        oe    <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise_i) begin
              rx_sh <= {rx_sh[DW-2:0], sda_s_i};
              cnt   <= cnt + 1'b1;
              if (cnt == CW'(DW-1)) done <= 1'b1;
            end else if (scl_fall_i && done) begin
              done <= 1'b0;
              if (state == ST_ADDR) begin
                if (rx_sh[DW-1:1] == DEV_ADDR) begin
                  oe       <= 1'b1;
                  rw       <= rx_sh[0];
                  wstart_o <= ~rx_sh[0];
                  state    <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                wr_stb_o <= 1'b1;
                oe       <= 1'b1;
                state    <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt <= '0;
              if (rw) begin
                tx_sh    <= rd_data_i;
                oe       <= ~rd_data_i[DW-1];
                rd_stb_o <= 1'b1;
                state    <= ST_RD;
              end else begin
                oe    <= 1'b0;
                state <= ST_WR;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              oe    <= 1'b0;
              cnt   <= '0;
              state <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall_i) begin
              cnt <= cnt + 1'b1;
              if (cnt == CW'(DW-1)) begin
                oe    <= 1'b0;
                state <= ST_RD_ACK;
              end else begin
                tx_sh <= {tx_sh[DW-2:0], 1'b0};
                oe    <= ~tx_sh[DW-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              mack <= ~sda_s_i;
            end else if (scl_fall_i) begin
              if (mack) begin
                tx_sh    <= rd_data_i;
                oe       <= ~rd_data_i[DW-1];
                rd_stb_o <= 1'b1;
                cnt      <= '0;
                state    <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe;
  assign wr_data_o = rx_sh;

  a_r12_stop_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o);
  a_r11_nack_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RD_ACK && scl_fall_i && !mack) |=> !sda_oe_o);
  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_stb_o, rd_stb_o, wstart_o}));
  a_r1_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && !start_i) |=> !sda_oe_o);
endmodule

// File: rtl/disp_i2c_regs.sv
module disp_i2c_regs
  import disp_i2c_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wstart_i,
  input  logic          wr_stb_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_stb_i,
  output logic [DW-1:0] rd_data_o,
  output logic          ddc_mode_o
);
  logic [DW-1:0] ptr;
  logic          load_pend, req, ddc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr       <= '0;
      load_pend <= 1'b0;
      req       <= 1'b0;
      ddc       <= 1'b0;
    end else begin
      if (wstart_i) load_pend <= 1'b1;
      if (wr_stb_i) begin
        if (load_pend) begin
          ptr       <= wr_data_i;
          load_pend <= 1'b0;
        end else begin
          if (ptr == REG_SYSCTL) begin
            if (wr_data_i[REQ_BIT]) begin
              req <= 1'b1;
              if (wr_data_i[GNT_BIT]) ddc <= 1'b1;
            end else begin
              req <= 1'b0;
              ddc <= 1'b0;
            end
          end
          ptr <= ptr + 1'b1;
        end
      end else if (rd_stb_i) begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (ptr)
      REG_SYSCTL: rd_data_o = req ? SYSCTL_ACK : '0;
      REG_ID:     rd_data_o = ID_VALUE;
      REG_IRQ:    rd_data_o = IRQ_PRESENT;
      default:    rd_data_o = '0;
    endcase
  end

  assign ddc_mode_o = ddc;

  a_r3_read_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && !wr_stb_i) |=> ptr == $past(ptr) + 8'd1);
  a_r2_ptr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && load_pend) |=> (ptr == $past(wr_data_i)) && $stable(ddc) && $stable(req));
  a_r4_mode_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ddc |-> req);
  a_r5_clear_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && !load_pend && ptr == REG_SYSCTL && !wr_data_i[REQ_BIT]) |=> (!ddc && !req));
  a_r9_other_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && !load_pend && ptr != REG_SYSCTL) |=> ($stable(ddc) && $stable(req)));
endmodule

// File: rtl/disp_i2c_target.sv
module disp_i2c_target
  import disp_i2c_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h39,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  output logic ddc_mode_o
);
  logic          sda_s, scl_rise, scl_fall, start, stop;
  logic          wstart, wr_stb, rd_stb;
  logic [DW-1:0] wr_data, rd_data;

  disp_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  disp_i2c_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe_o),
    .wstart_o   (wstart),
    .wr_stb_o   (wr_stb),
    .wr_data_o  (wr_data),
    .rd_stb_o   (rd_stb)
  );

  disp_i2c_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wstart_i   (wstart),
    .wr_stb_i   (wr_stb),
    .wr_data_i  (wr_data),
    .rd_stb_i   (rd_stb),
    .rd_data_o  (rd_data),
    .ddc_mode_o (ddc_mode_o)
  );
endmodule

// File: tb/disp_i2c_target_tb_top.sv
module disp_i2c_target_tb_top;
  localparam logic [6:0] DEV = 7'h39;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, ddc_mode;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit req_m = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  disp_i2c_target #(.DEV_ADDR(DEV), .SYNC_STAGES(2)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .sda_oe_o   (sda_oe),
    .ddc_mode_o (ddc_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_val(input logic [7:0] a);
    if (a == 8'h1A) return req_m ? 8'h06 : 8'h00;
    if (a == 8'h1B) return 8'hB0;
    if (a == 8'h3D) return 8'h04;
    return 0;
  endfunction

  task automatic wt();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wt(); scl_m = 1'b1; wt(); sda_m = 1'b0; wt(); scl_m = 1'b0; wt();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wt(); scl_m = 1'b1; wt(); sda_m = 1'b1; wt();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wt(); scl_m = 1'b1; wt(); wt(); scl_m = 1'b0; wt();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wt(); scl_m = 1'b1; wt(); b = sda_bus; wt(); scl_m = 1'b0; wt();
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~mack);
  endtask

  // read n bytes from the current pointer p0, checking each
  task automatic read_run(input logic [7:0] p0, input int n, input string req);
    logic [7:0] d;
    logic a;
    write_byte({DEV, 1'b1}, a);
    chk("R1 read header ack", int'(a), 1);
    for (int i = 0; i < n; i++) begin
      read_byte(i != n - 1, d);
      chk(req, int'(d), exp_val(p0 + 8'(i)));
    end
    chk("R11 released after NACK", int'(sda_oe), 0);
  endtask

  task automatic rd_from(input logic [7:0] p, input int n, input string req);
    logic a;
    i2c_start();
    write_byte({DEV, 1'b0}, a);
    chk("R1 write header ack", int'(a), 1);
    write_byte(p, a);
    chk("R2 pointer byte ack", int'(a), 1);
    i2c_start();
    read_run(p, n, req);
    i2c_stop();
  endtask

  task automatic wr_to(input logic [7:0] p, input logic [7:0] d);
    logic a;
    i2c_start();
    write_byte({DEV, 1'b0}, a);
    chk("R1 write header ack", int'(a), 1);
    write_byte(p, a);
    chk("R2 pointer byte ack", int'(a), 1);
    write_byte(d, a);
    chk("R9 data byte ack", int'(a), 1);
    i2c_stop();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    chk("R10 ddc after reset", int'(ddc_mode), 0);
    chk("R10 sda released in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    wt();
    chk("R10 sda released after reset", int'(sda_oe), 0);

    // R10 R3 R7 R8 R9: pointer starts at 0, sweep 0x00..0x3F
    i2c_start();
    read_run(8'h00, 64, "R10 R3 R7 R8 R9 sweep from reset");
    i2c_stop();

    // R1: foreign headers are not acknowledged and cause nothing
    i2c_start();
    write_byte({7'h38, 1'b0}, a);
    chk("R1 near-miss header nack", int'(a), 0);
    write_byte(8'h1A, a);
    write_byte(8'h06, a);
    i2c_stop();
    chk("R1 foreign traffic ignored", int'(ddc_mode), 0);
    i2c_start();
    write_byte({7'h50, 1'b1}, a);
    chk("R1 far header nack", int'(a), 0);
    i2c_stop();
    rd_from(8'h1A, 1, "R1 R6 no request after foreign write");

    // R4 R6 R11: request only, repeated START read keeps pointer
    wr_to(8'h1A, 8'h04);
    req_m = 1'b1;
    chk("R4 request alone no mode", int'(ddc_mode), 0);
    rd_from(8'h1A, 2, "R6 R11 request pending readback");

    // R4: request + grant enters mode
    wr_to(8'h1A, 8'h06);
    chk("R4 request and grant sets mode", int'(ddc_mode), 1);
    // R5: clear
    wr_to(8'h1A, 8'h02);
    req_m = 1'b0;
    chk("R5 grant without request clears", int'(ddc_mode), 0);
    rd_from(8'h1A, 1, "R5 R6 cleared readback");

    // R3: wrap modulo 256 on reads
    rd_from(8'hFE, 30, "R3 read wrap");

    // R3: write auto-increment reaches 0x1A
    i2c_start();
    write_byte({DEV, 1'b0}, a);
    write_byte(8'h18, a);
    write_byte(8'h06, a);
    write_byte(8'h06, a);
    write_byte(8'h06, a);
    chk("R3 third data byte ack", int'(a), 1);
    i2c_stop();
    req_m = 1'b1;
    chk("R3 write stepping reaches 0x1A", int'(ddc_mode), 1);
    // R3 write wrap: 0xFF then 0x00 .. 0x1A
    i2c_start();
    write_byte({DEV, 1'b0}, a);
    write_byte(8'hFF, a);
    for (int i = 0; i < 28; i++) write_byte(8'h00, a);
    i2c_stop();
    req_m = 1'b0;
    chk("R3 write wrap clears at 0x1A", int'(ddc_mode), 0);

    // R2: pointer byte is never a register write
    rd_from(8'h19, 1, "R2 setup read");
    i2c_start();
    write_byte({DEV, 1'b0}, a);
    write_byte(8'h06, a);
    i2c_stop();
    chk("R2 pointer byte not applied", int'(ddc_mode), 0);
    i2c_start();
    read_run(8'h06, 22, "R2 pointer loaded from first byte");
    i2c_stop();

    // R9: writes to other locations discarded
    i2c_start();
    write_byte({DEV, 1'b0}, a);
    write_byte(8'h1B, a);
    write_byte(8'h12, a);
    write_byte(8'h06, a);
    chk("R9 write to 0x1C ack", int'(a), 1);
    i2c_stop();
    chk("R9 write to 0x1C no mode", int'(ddc_mode), 0);
    wr_to(8'h3D, 8'hFF);
    rd_from(8'h1B, 3, "R9 R7 after discarded writes");
    rd_from(8'h3D, 1, "R9 R8 after discarded write");

    // R12: START mid-byte
    wr_to(8'h1A, 8'h04);
    req_m = 1'b1;
    i2c_start();
    write_byte({DEV, 1'b0}, a);
    write_byte(8'h1A, a);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    i2c_start();
    read_run(8'h1A, 1, "R12 partial byte before START dropped");
    i2c_stop();
    // R12: STOP mid-byte
    i2c_start();
    write_byte({DEV, 1'b0}, a);
    write_byte(8'h1A, a);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    i2c_stop();
    rd_from(8'h1A, 1, "R12 partial byte before STOP dropped");
    // R12: STOP during read releases line
    i2c_start();
    write_byte({DEV, 1'b1}, a);
    send_bit(1'b1); send_bit(1'b1);
    i2c_stop();
    chk("R12 STOP mid-read releases", int'(sda_oe), 0);
    wr_to(8'h1A, 8'h00);
    req_m = 1'b0;
    chk("R5 final clear", int'(ddc_mode), 0);

    finished = 1'b1;
    finish_run();
  end
endmodule